// File: doc/BRIEF.md
# Streaming k-curvature contour thinner

This block reduces a traced contour to its dominant points while the contour is still streaming in. Each point of a contour is taken once. For a centre point, the block forms two vectors: one to the point k places later in the stream and one to the point k places earlier. It keeps the centre when the angle between those vectors is at or below a programmable limit. Kept points leave as a write strobe with coordinates, ready to be appended to a contour stack. No divider and no square root are used. The squared cosine, taken as the squared dot product over the product of the two squared lengths, is compared with a squared-cosine threshold by cross-multiplication. The sign of the dot product separates acute angles from obtuse ones.

A contour is marked by a first-point flag and a last-point flag. The first point is always stored, and so is the last point, so that the thinned polygon closes. No more than seven evaluated points in a row may be discarded. The next one is stored regardless, and counting restarts from it. The window distance k is captured when a contour starts. Each arriving point is the forward neighbour of the centre it completes, so one centre is decided per input point. The result is registered one cycle later.

Top module: `kcurve_thin`

## Requirements
- R1: While `rst` is high and afterwards until a point is accepted, `st_we` stays low.
- R2: A point accepted with `pt_first` high is written one cycle later with its own coordinates, whatever the window holds. It also clears the run-of-discards counter.
- R3: k is sampled from `cfg_k` only with a first point. A value of 0 selects 4, values above 9 select 9, and 1 to 9 are used as given. Changes to `cfg_k` later in the same contour have no effect.
- R4: Points are numbered from 0 within a contour. When point j arrives with j >= 2k, centre j-k is evaluated against forward point j and backward point j-2k. Points 1 to k-1 and the last k-1 points before the closing point are never evaluated and are never written.
- R5: With a = P(j)-P(c) and b = P(j-2k)-P(c), the squared cosine is (a·b)^2 / (|a|^2 |b|^2). The threshold `cfg_thr_cos2` gives the squared cosine of the limit angle as an unsigned fraction with 16 fraction bits, so 65536 means 1.0. `cfg_thr_obtuse` high means the limit angle is above 90 degrees.
- R6: An evaluated centre is kept when its angle is at or below the limit. With a non-negative dot product, it is kept if `cfg_thr_obtuse` is high, and otherwise if dot^2·65536 >= |a|^2|b|^2·thr. With a negative dot product, it is dropped if `cfg_thr_obtuse` is low, and otherwise kept if dot^2·65536 <= |a|^2|b|^2·thr.
- R7: After seven evaluated centres in a row are dropped, the eighth evaluated centre is written whatever its angle. Every written point restarts the count.
- R8: For a contour of more than one point, the point carrying `pt_last` is written in the cycle after the write slot of its own arrival. `pt_valid` must be low in that cycle. A point with both flags high is written once.
- R9: Written points appear in contour order. A kept centre is written exactly one cycle after the arrival that completes its window.
- R10: An obtuse threshold of 65536 (180 degrees) keeps every evaluated centre. A non-obtuse threshold of 65536 (0 degrees) keeps only centres whose two neighbours point the same way, apart from forced keeps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_valid | input | 1 | Contour point present this cycle |
| pt_first | input | 1 | Point opens a new contour |
| pt_last | input | 1 | Point closes the current contour |
| pt_x | input | XW (9) | Point column |
| pt_y | input | YW (8) | Point row |
| cfg_k | input | KW (4) | Window distance, captured at first point |
| cfg_thr_cos2 | input | FRAC+1 (17) | Squared cosine of the limit angle, 16 fraction bits |
| cfg_thr_obtuse | input | 1 | Limit angle is above 90 degrees |
| st_we | output | 1 | Write strobe into the contour stack |
| st_x | output | XW (9) | Column of the stored point |
| st_y | output | YW (8) | Row of the stored point |

## Verification
Internal state that goes wrong shows up as a changed sequence of stored points. A wrong window tap or a wrong captured k moves the kept corners to other coordinates, starting with the first evaluation of the contour, at point 2k. A run-of-discards counter that miscounts moves or loses the forced write on a straight run within eight evaluations. A closing point that is lost or delayed shows up two cycles after `pt_last`. Every stored point is compared in order, and together with the exact cycle it should appear in, so any slip in timing or in sequence shows up at that point.

// File: rtl/kcurve_pkg.sv
`timescale 1ns/1ps
package kcurve_pkg;
  // window distance used when the configured value is zero
  localparam int K_DEFAULT = 4;

  // map a raw configured distance onto the supported range
  function automatic int unsigned k_clamp(input int unsigned raw,
                                          input int unsigned kmax,
                                          input int unsigned kdef);
    if (raw == 0) return kdef;
    if (raw > kmax) return kmax;
    return raw;
  endfunction
endpackage

// File: rtl/kcurve_window.sv
`timescale 1ns/1ps
module kcurve_window #(
  parameter int XW   = 9,
  parameter int YW   = 8,
  parameter int KMAX = 9,
  localparam int KW  = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  input  logic [KW-1:0] k,
  output logic [XW-1:0] ctr_x,
  output logic [YW-1:0] ctr_y,
  output logic [XW-1:0] back_x,
  output logic [YW-1:0] back_y
);
  // stored history; the incoming point is the forward tap, so
  // 2*KMAX stored entries plus the live point span the full window
  localparam int DEPTH = 2 * KMAX;
  localparam int IW    = $clog2(DEPTH);

  logic [XW-1:0] hx [DEPTH];
  logic [YW-1:0] hy [DEPTH];
  logic [IW-1:0] ci, bi;

  // data shift chain without reset so it maps onto shift-register primitives
  always_ff @(posedge clk) begin
    if (push) begin
      hx[0] <= in_x;
      hy[0] <= in_y;
      for (int i = 1; i < DEPTH; i++) begin
        hx[i] <= hx[i-1];
        hy[i] <= hy[i-1];
      end
    end
  end

  always_comb begin
    ci     = IW'(int'(k) - 1);
    bi     = IW'(2 * int'(k) - 1);
    ctr_x  = hx[ci];
    ctr_y  = hy[ci];
    back_x = hx[bi];
    back_y = hy[bi];
  end

  // R3
  k_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(k) >= 1) && (int'(k) <= KMAX));
endmodule

// File: rtl/kcurve_angle.sv
`timescale 1ns/1ps
module kcurve_angle #(
  parameter int XW   = 9,
  parameter int YW   = 8,
  parameter int FRAC = 16
) (
  input  logic [XW-1:0] fwd_x,
  input  logic [YW-1:0] fwd_y,
  input  logic [XW-1:0] ctr_x,
  input  logic [YW-1:0] ctr_y,
  input  logic [XW-1:0] bwd_x,
  input  logic [YW-1:0] bwd_y,
  input  logic [FRAC:0] thr_cos2,
  input  logic          thr_obtuse,
  output logic          keep
);
  localparam int DW = ((XW > YW) ? XW : YW) + 1;
  localparam int PW = 2 * DW + 1;
  localparam int CW = 2 * PW + FRAC + 1;

  logic signed [PW-1:0] ax, ay, bx, by, dot;
  logic [PW-1:0] la, lb, mag;
  logic [CW-1:0] lhs, rhs;
  logic          acute;

  always_comb begin
    ax  = PW'($signed({1'b0, fwd_x})) - PW'($signed({1'b0, ctr_x}));
    ay  = PW'($signed({1'b0, fwd_y})) - PW'($signed({1'b0, ctr_y}));
    bx  = PW'($signed({1'b0, bwd_x})) - PW'($signed({1'b0, ctr_x}));
    by  = PW'($signed({1'b0, bwd_y})) - PW'($signed({1'b0, ctr_y}));
    dot = ax * bx + ay * by;
    la  = PW'(ax * ax + ay * ay);
    lb  = PW'(bx * bx + by * by);
    mag = dot[PW-1] ? PW'(-dot) : PW'(dot);
    acute = ~dot[PW-1];
    // squared cosine against threshold without a divider
    lhs = (CW'(mag) * CW'(mag)) << FRAC;
    rhs = CW'(la) * CW'(lb) * CW'(thr_cos2);
    unique case ({acute, thr_obtuse})
      2'b11:   keep = 1'b1;
      2'b10:   keep = (lhs >= rhs);
      2'b01:   keep = (lhs <= rhs);
      default: keep = 1'b0;
    endcase
  end
endmodule

// File: rtl/kcurve_ctrl.sv
`timescale 1ns/1ps
module kcurve_ctrl #(
  parameter int XW   = 9,
  parameter int YW   = 8,
  parameter int KMAX = 9,
  parameter int SKW  = 3,
  localparam int KW  = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  input  logic [KW-1:0] cfg_k,
  input  logic [XW-1:0] ctr_x,
  input  logic [YW-1:0] ctr_y,
  input  logic          angle_keep,
  output logic [KW-1:0] k_cur,
  output logic          st_we,
  output logic [XW-1:0] st_x,
  output logic [YW-1:0] st_y
);
  localparam int SEENMAX = 2 * KMAX;
  localparam int CNTW    = $clog2(SEENMAX + 1);
  localparam logic [SKW-1:0] SKIPMAX = '1;

  logic [CNTW-1:0] seen;
  logic [SKW-1:0]  skip;
  logic            pend;
  logic [XW-1:0]   pend_x;
  logic [YW-1:0]   pend_y;
  logic [KW-1:0]   k_new;
  logic            enough;

  always_comb begin
    k_new  = KW'(kcurve_pkg::k_clamp(int'(cfg_k), KMAX, kcurve_pkg::K_DEFAULT));
    enough = (seen >= CNTW'(2 * int'(k_cur)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_cur  <= KW'(kcurve_pkg::K_DEFAULT);
      seen   <= '0;
      skip   <= '0;
      pend   <= 1'b0;
      pend_x <= '0;
      pend_y <= '0;
      st_we  <= 1'b0;
      st_x   <= '0;
      st_y   <= '0;
    end else begin
      st_we <= 1'b0;
      if (pend) begin
        st_we <= 1'b1;
        st_x  <= pend_x;
        st_y  <= pend_y;
        pend  <= 1'b0;
      end
      if (in_valid) begin
        if (in_first) begin
          k_cur <= k_new;
          seen  <= CNTW'(1);
          skip  <= '0;
          st_we <= 1'b1;
          st_x  <= in_x;
          st_y  <= in_y;
        end else begin
          if (int'(seen) < SEENMAX) seen <= seen + 1'b1;
          if (enough) begin
            if (angle_keep || (skip == SKIPMAX)) begin
              st_we <= 1'b1;
              st_x  <= ctr_x;
              st_y  <= ctr_y;
              skip  <= '0;
            end else begin
              skip <= skip + 1'b1;
            end
          end
          if (in_last) begin
            pend   <= 1'b1;
            pend_x <= in_x;
            pend_y <= in_y;
          end
        end
      end
    end
  end

  // R2
  first_emit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |=> (st_we && st_x == $past(in_x) && st_y == $past(in_y)));
  // R2
  first_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |=> (skip == '0));
  // R7
  forced_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_first && enough && skip == SKIPMAX) |=> (st_we && skip == '0));
  // R8
  gap_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> !in_valid);
  // R1
  write_origin_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> ($past(in_valid) || $past(pend)));
endmodule

// File: rtl/kcurve_thin.sv
`timescale 1ns/1ps
module kcurve_thin #(
  parameter int XW   = 9,
  parameter int YW   = 8,
  parameter int KMAX = 9,
  parameter int FRAC = 16,
  parameter int SKW  = 3,
  localparam int KW  = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pt_valid,
  input  logic          pt_first,
  input  logic          pt_last,
  input  logic [XW-1:0] pt_x,
  input  logic [YW-1:0] pt_y,
  input  logic [KW-1:0] cfg_k,
  input  logic [FRAC:0] cfg_thr_cos2,
  input  logic          cfg_thr_obtuse,
  output logic          st_we,
  output logic [XW-1:0] st_x,
  output logic [YW-1:0] st_y
);
  logic [KW-1:0] k_cur;
  logic [XW-1:0] ctr_x, back_x;
  logic [YW-1:0] ctr_y, back_y;
  logic          angle_keep;

  kcurve_window #(.XW(XW), .YW(YW), .KMAX(KMAX)) u_window (
    .clk(clk), .rst(rst), .push(pt_valid), .in_x(pt_x), .in_y(pt_y),
    .k(k_cur), .ctr_x(ctr_x), .ctr_y(ctr_y), .back_x(back_x), .back_y(back_y)
  );

  kcurve_angle #(.XW(XW), .YW(YW), .FRAC(FRAC)) u_angle (
    .fwd_x(pt_x), .fwd_y(pt_y), .ctr_x(ctr_x), .ctr_y(ctr_y),
    .bwd_x(back_x), .bwd_y(back_y), .thr_cos2(cfg_thr_cos2),
    .thr_obtuse(cfg_thr_obtuse), .keep(angle_keep)
  );

  kcurve_ctrl #(.XW(XW), .YW(YW), .KMAX(KMAX), .SKW(SKW)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(pt_valid), .in_first(pt_first),
    .in_last(pt_last), .in_x(pt_x), .in_y(pt_y), .cfg_k(cfg_k),
    .ctr_x(ctr_x), .ctr_y(ctr_y), .angle_keep(angle_keep),
    .k_cur(k_cur), .st_we(st_we), .st_x(st_x), .st_y(st_y)
  );
endmodule

// File: tb/kcurve_thin_test.sv
`timescale 1ns/1ps
module kcurve_thin_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pt_valid = 1'b0, pt_first = 1'b0, pt_last = 1'b0;
  logic [8:0]  pt_x = '0;
  logic [7:0]  pt_y = '0;
  logic [3:0]  cfg_k = '0;
  logic [16:0] cfg_thr_cos2 = '0;
  logic        cfg_thr_obtuse = 1'b0;
  logic        st_we;
  logic [8:0]  st_x;
  logic [7:0]  st_y;

  kcurve_thin uut (
    .clk(clk), .rst(rst), .pt_valid(pt_valid), .pt_first(pt_first),
    .pt_last(pt_last), .pt_x(pt_x), .pt_y(pt_y), .cfg_k(cfg_k),
    .cfg_thr_cos2(cfg_thr_cos2), .cfg_thr_obtuse(cfg_thr_obtuse),
    .st_we(st_we), .st_x(st_x), .st_y(st_y)
  );

  always #5 clk = ~clk;

  typedef struct { int x; int y; longint cyc; string tag; } exp_t;
  exp_t   q[$];
  exp_t   e;
  int     checks = 0, errors = 0;
  longint cyc = 0;
  bit     done = 1'b0;
  int     ca_x[256], ca_y[256];
  int     cn = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items as the design writes
  always @(negedge clk) begin
    if (!rst && st_we) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected write actual (%0d,%0d) expected none", st_x, st_y);
      end else begin
        e = q.pop_front();
        if (int'(st_x) != e.x || int'(st_y) != e.y || cyc != e.cyc) begin
          errors++;
          $display("FAIL %s R9 actual (%0d,%0d)@%0d expected (%0d,%0d)@%0d",
                   e.tag, st_x, st_y, cyc, e.x, e.y, e.cyc);
        end
      end
    end
  end

  function automatic int clamp_k(input int raw);
    if (raw == 0) return 4;
    if (raw > 9) return 9;
    return raw;
  endfunction

  // R5 R6: reference keep decision from the stated squared-cosine rule
  function automatic bit ref_keep(input int ax, input int ay, input int bx,
                                  input int by, input longint thr, input bit obt);
    longint dot, la, lb, lhs, rhs;
    dot = longint'(ax) * bx + longint'(ay) * by;
    la  = longint'(ax) * ax + longint'(ay) * ay;
    lb  = longint'(bx) * bx + longint'(by) * by;
    lhs = dot * dot * 65536;
    rhs = la * lb * thr;
    if (dot >= 0) return obt ? 1'b1 : (lhs >= rhs);
    return obt ? (lhs <= rhs) : 1'b0;
  endfunction

  function automatic exp_t mk(input int x, input int y, input longint c, input string t);
    exp_t r;
    r.x = x; r.y = y; r.cyc = c; r.tag = t;
    return r;
  endfunction

  task automatic add_line(input int x0, input int y0, input int dx, input int dy, input int n);
    for (int i = 0; i < n; i++) begin
      ca_x[cn] = x0 + i * dx;
      ca_y[cn] = y0 + i * dy;
      cn++;
    end
  endtask

  // driver: sends the staged contour and pushes expected writes
  task automatic send_contour(input int kcfg, input int kmid, input int thr, input bit obt);
    int kk, skip, c, m;
    bit kp;
    kk = clamp_k(kcfg);
    skip = 0;
    for (int i = 0; i < cn; i++) begin
      @(negedge clk);
      if (i == 0) cfg_k = 4'(kcfg);
      else if (i == 3 && kmid >= 0) cfg_k = 4'(kmid);   // R3 mid-contour change
      cfg_thr_cos2 = 17'(thr);
      cfg_thr_obtuse = obt;
      pt_valid = 1'b1;
      pt_first = (i == 0);
      pt_last  = (i == cn - 1);
      pt_x = 9'(ca_x[i]);
      pt_y = 8'(ca_y[i]);
      if (i == 0) begin
        q.push_back(mk(ca_x[0], ca_y[0], cyc + 1, "R2 first point"));
      end else if (i >= 2 * kk) begin
        c = i - kk;
        m = i - 2 * kk;
        kp = ref_keep(ca_x[i] - ca_x[c], ca_y[i] - ca_y[c],
                      ca_x[m] - ca_x[c], ca_y[m] - ca_y[c], thr, obt);
        if (kp) begin
          q.push_back(mk(ca_x[c], ca_y[c], cyc + 1, "R6 angle keep"));
          skip = 0;
        end else if (skip == 7) begin
          q.push_back(mk(ca_x[c], ca_y[c], cyc + 1, "R7 forced keep"));
          skip = 0;
        end else begin
          skip++;
        end
      end
      if (i == cn - 1 && cn > 1)
        q.push_back(mk(ca_x[i], ca_y[i], cyc + 2, "R8 closing point"));
    end
    @(negedge clk);
    pt_valid = 1'b0;
    pt_first = 1'b0;
    pt_last  = 1'b0;
    cn = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: no write during reset
    checks++;
    if (st_we !== 1'b0) begin
      errors++;
      $display("FAIL R1 st_we during reset actual %0b expected 0", st_we);
    end
    rst = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (st_we !== 1'b0) begin
      errors++;
      $display("FAIL R1 st_we idle after reset actual %0b expected 0", st_we);
    end

    // R4 R7: straight run, default k via 0, 70 degree limit
    add_line(10, 40, 1, 0, 20);
    send_contour(0, -1, 7666, 1'b0);

    // R6: sharp spike, k=2
    add_line(10, 100, 1, -3, 7);
    add_line(17, 82, 1, 3, 7);
    send_contour(2, -1, 7666, 1'b0);

    // R6 obtuse branch: square, k=1, 120 degree limit
    add_line(50, 50, 1, 0, 6);
    add_line(56, 50, 0, 1, 6);
    add_line(56, 56, -1, 0, 6);
    add_line(50, 56, 0, -1, 6);
    send_contour(1, -1, 16384, 1'b1);

    // R3: k above range clamps to 9; later cfg change ignored; 90 degree limit
    add_line(100, 20, 1, 0, 12);
    add_line(112, 20, 0, 2, 12);
    add_line(112, 44, -2, 0, 10);
    send_contour(12, 1, 0, 1'b0);

    // R10: 180 degree limit keeps every evaluated centre
    for (int i = 0; i < 15; i++) begin
      ca_x[cn] = 20 + i; ca_y[cn] = 30 + (i % 3) * 2; cn++;
    end
    send_contour(3, -1, 65536, 1'b1);

    // R10: 0 degree limit keeps only folded-back centres (plus forced)
    for (int i = 0; i < 15; i++) begin
      ca_x[cn] = 20 + i; ca_y[cn] = 30 + (i % 3) * 2; cn++;
    end
    send_contour(3, -1, 65536, 1'b0);

    // R8: single-point contour and short contour without evaluation
    add_line(200, 200, 0, 0, 1);
    send_contour(4, -1, 7666, 1'b0);
    add_line(210, 210, 1, 1, 3);
    send_contour(0, -1, 7666, 1'b0);

    // R4 R9: back-to-back contour with a spike, k=4
    add_line(150, 150, 1, 0, 10);
    add_line(160, 150, -1, 1, 10);
    send_contour(4, -1, 7666, 1'b0);

    repeat (6) @(negedge clk);
    // R9: every expected write seen
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending expected writes actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule